// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index marker of an incremental shaft encoder into a position count. All three inputs are asynchronous. Each one is brought into the clock domain through its own flop chain. The decoder compares the synchronized A/B pair with its value one cycle earlier. A legal Gray step moves a wrapping position count up or down by one. An illegal step, where both phases change at once, leaves the count alone and sets a sticky error flag.

The index marker can clear the count in one of two modes:
- Continuous mode: every marker clears the count.
- Single-marker mode: only the first marker after the counter is enabled clears it.

A loop timer reloads from a programmable period and pulses an interrupt each time it expires. When the timer is linked to the counter, the same edge also copies the position count into a snapshot register. When it is unlinked, it is a plain periodic timer. Status outputs show the synchronized input levels.

Top module: `enc_qei_top`

## Requirements
- R1: After reset, and on every clock while `enable_i` is low, `count_o` is 0 and `err_o` is 0. After reset, `snapshot_o` is 0 and `loop_irq_o` is 0.
- R2: The phase pair {A,B} moves through a Gray cycle. The forward order is 00 -> 10 -> 11 -> 01 -> 00, and each forward step raises `count_o` by one. Each step in the reverse order lowers it by one. The new count is visible no later than the third rising clock edge after the input change.
- R3: A transition in which A and B change on the same synchronized sample leaves `count_o` unchanged. It sets `err_o`, which stays at 1 until `enable_i` goes low.
- R4: A forward step from a count equal to or above `max_count_i` gives 0. A reverse step from 0 gives `max_count_i`.
- R5: When `zero_rst_en_i` is 1 and `single_mark_i` is 0, every rising edge of the synchronized marker sets `count_o` to 0.
- R6: When `zero_rst_en_i` is 1 and `single_mark_i` is 1, only the first marker rising edge after reset, or after `enable_i` rises, clears the count. Later markers leave `count_o` unchanged.
- R7: When `zero_rst_en_i` is 0, marker edges have no effect on `count_o`.
- R8: `status_o` is {marker, B, A} as seen after the two-stage synchronizer, so `status_o[0]` is A, `status_o[1]` is B and `status_o[2]` is the marker.
- R9: While `loop_en_i` is 1, `loop_irq_o` is a one-cycle pulse repeating every `loop_period_i`+1 clock cycles.
- R10: When `loop_link_i` is 1, `snapshot_o` takes the value of `count_o` in the cycle the interrupt pulse appears. It changes at no other time.
- R11: When `loop_link_i` is 0, the timer still pulses `loop_irq_o` but `snapshot_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| enc_z_i | input | 1 | Index marker, asynchronous |
| enable_i | input | 1 | Counter enable; low clears count and error and re-arms single-marker mode |
| zero_rst_en_i | input | 1 | Allow the marker to clear the count |
| single_mark_i | input | 1 | Only the first marker after enabling clears the count |
| max_count_i | input | 16 | Wrap point of the position count |
| loop_en_i | input | 1 | Run the loop timer |
| loop_link_i | input | 1 | Copy the count into the snapshot on timer expiry |
| loop_period_i | input | 16 | Timer reload value (period minus one) |
| count_o | output | 16 | Position count |
| snapshot_o | output | 16 | Count captured by the loop timer |
| loop_irq_o | output | 1 | One-cycle timer expiry pulse |
| err_o | output | 1 | Sticky illegal-transition flag |
| status_o | output | 3 | Synchronized {marker, B, A} |

## Verification
The decoder is driven in a seeded random walk of forward, reverse and double-toggle steps under a small wrap point. A model computes the expected count from Gray position differences, so the walk separates direction errors, wrap errors and the handling of illegal steps. Directed marker pulses tell continuous clearing apart from the first-marker-only mode and from a disabled marker. The loop timer is run with and without linking, which separates the pulse spacing from the snapshot capture.

// File: rtl/enc_qei_pkg.sv
package enc_qei_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Gray position of {a,b}: 00->0, 10->1, 11->2, 01->3
  function automatic logic [1:0] gray_pos(input logic a, input logic b);
    return {a & b | ~a & b, a ^ b};
  endfunction
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/enc_decoder.sv
module enc_decoder
  import enc_qei_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  a_i,
  input  logic  b_i,
  input  logic  z_i,
  output step_e step_o,
  output logic  z_rise_o
);
  logic a_q, b_q, z_q;
  logic [1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      z_q <= z_i;
    end
  end

  assign diff = gray_pos(a_i, b_i) - gray_pos(a_q, b_q);

  always_comb begin
    unique case (diff)
      2'd1:    step_o = STEP_UP;
      2'd3:    step_o = STEP_DN;
      2'd2:    step_o = STEP_BAD;
      default: step_o = STEP_NONE;
    endcase
  end

  assign z_rise_o = z_i & ~z_q;
endmodule

// File: rtl/enc_position.sv
module enc_position
  import enc_qei_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  step_e            step_i,
  input  logic             z_rise_i,
  input  logic             zero_rst_en_i,
  input  logic             single_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] count_o,
  output logic             err_o
);
  logic armed_q;
  logic mark_hit;

  assign mark_hit = z_rise_i & zero_rst_en_i & (~single_i | armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      err_o   <= 1'b0;
      armed_q <= 1'b1;
    end else if (!en_i) begin
      count_o <= '0;
      err_o   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (step_i == STEP_BAD) err_o <= 1'b1;
      if (mark_hit) begin
        count_o <= '0;
        if (single_i) armed_q <= 1'b0;
      end else begin
        unique case (step_i)
          STEP_UP: count_o <= (count_o >= max_i) ? '0 : count_o + CNT_W'(1);
          STEP_DN: count_o <= (count_o == '0) ? max_i : count_o - CNT_W'(1);
          default: count_o <= count_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/enc_loop_timer.sv
module enc_loop_timer #(
  parameter int TMR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             link_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             irq_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      irq_o  <= 1'b0;
      snap_o <= '0;
    end else if (!en_i) begin
      tmr_q  <= period_i;
      irq_o  <= 1'b0;
    end else if (tmr_q == '0) begin
      tmr_q  <= period_i;
      irq_o  <= 1'b1;
      if (link_i) snap_o <= count_i;
    end else begin
      tmr_q  <= tmr_q - TMR_W'(1);
      irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/enc_qei_top.sv
module enc_qei_top
  import enc_qei_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TMR_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic             enc_z_i,
  input  logic             enable_i,
  input  logic             zero_rst_en_i,
  input  logic             single_mark_i,
  input  logic [CNT_W-1:0] max_count_i,
  input  logic             loop_en_i,
  input  logic             loop_link_i,
  input  logic [TMR_W-1:0] loop_period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snapshot_o,
  output logic             loop_irq_o,
  output logic             err_o,
  output logic [2:0]       status_o
);
  localparam int NIN = 3;

  logic [NIN-1:0] sync_q;
  step_e          step;
  logic           z_rise;

  enc_sync #(.WIDTH(NIN), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_z_i, enc_b_i, enc_a_i}),
    .q_o    (sync_q)
  );

  assign status_o = sync_q;

  enc_decoder u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (sync_q[0]),
    .b_i      (sync_q[1]),
    .z_i      (sync_q[2]),
    .step_o   (step),
    .z_rise_o (z_rise)
  );

  enc_position #(.CNT_W(CNT_W)) u_pos (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (enable_i),
    .step_i        (step),
    .z_rise_i      (z_rise),
    .zero_rst_en_i (zero_rst_en_i),
    .single_i      (single_mark_i),
    .max_i         (max_count_i),
    .count_o       (count_o),
    .err_o         (err_o)
  );

  enc_loop_timer #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (loop_en_i),
    .link_i   (loop_link_i),
    .period_i (loop_period_i),
    .count_i  (count_o),
    .snap_o   (snapshot_o),
    .irq_o    (loop_irq_o)
  );
endmodule

// File: rtl/enc_qei_chk.sv
module enc_qei_chk #(
  parameter int CNT_W = 16,
  parameter int TMR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [CNT_W-1:0] max_count_i,
  input logic             loop_en_i,
  input logic             loop_link_i,
  input logic [TMR_W-1:0] loop_period_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] snapshot_o,
  input logic             loop_irq_o,
  input logic             err_o
);
  p_disabled_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (count_o == '0) && !err_o);

  // R2 / R4: count moves by one, wraps, or is cleared
  p_step_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o != $past(count_o) |->
      (count_o == $past(count_o) + CNT_W'(1)) || (count_o == $past(count_o) - CNT_W'(1)) ||
      (count_o == '0) || (count_o == $past(max_count_i)));

  p_err_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (count_o == $past(count_o)) || (count_o == '0));

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_irq_o && loop_en_i && (loop_period_i != '0) |=> !loop_irq_o);

  p_snap_only_linked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snapshot_o != $past(snapshot_o) |-> loop_irq_o && $past(loop_link_i));

  p_no_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |=> !loop_irq_o);
endmodule

bind enc_qei_top enc_qei_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .max_count_i   (max_count_i),
  .loop_en_i     (loop_en_i),
  .loop_link_i   (loop_link_i),
  .loop_period_i (loop_period_i),
  .count_o       (count_o),
  .snapshot_o    (snapshot_o),
  .loop_irq_o    (loop_irq_o),
  .err_o         (err_o)
);

// File: tb/tb_enc_qei_top.sv
`timescale 1ns/1ps
module tb_enc_qei_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a = 0, b = 0, z = 0;
  logic        en = 0, zen = 0, single = 0;
  logic [15:0] maxc = 16'd10;
  logic        len = 0, link = 0;
  logic [15:0] period = 16'd7;
  logic [15:0] count, snap;
  logic        irq, err;
  logic [2:0]  status;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  bit exp_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  enc_qei_top dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b), .enc_z_i(z),
    .enable_i(en), .zero_rst_en_i(zen), .single_mark_i(single),
    .max_count_i(maxc), .loop_en_i(len), .loop_link_i(link),
    .loop_period_i(period), .count_o(count), .snapshot_o(snap),
    .loop_irq_o(irq), .err_o(err), .status_o(status)
  );

  function automatic int gpos(input bit pa, input bit pb);
    return pa ? (pb ? 2 : 1) : (pb ? 3 : 0);
  endfunction

  function automatic int model_next(input int c, input int d, input int mx);
    if (d == 1) return (c >= mx) ? 0 : c + 1;
    if (d == 3) return (c == 0) ? mx : c - 1;
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // apply new phase levels, update the model, wait past the 3-edge latency
  task automatic move(input bit na, input bit nb);
    int d;
    d = (gpos(na, nb) - gpos(a, b) + 4) % 4;
    if (d == 2) exp_err = 1;
    else exp_cnt = model_next(exp_cnt, d, int'(maxc));
    a = na; b = nb;
    cyc(4);
  endtask

  task automatic fwd();
    case (gpos(a, b))
      0: move(1, 0);
      1: move(1, 1);
      2: move(0, 1);
      default: move(0, 0);
    endcase
  endtask

  task automatic rev();
    case (gpos(a, b))
      0: move(0, 1);
      1: move(0, 0);
      2: move(1, 0);
      default: move(1, 1);
    endcase
  endtask

  task automatic pulse_z();
    z = 1; cyc(4);
    z = 0; cyc(4);
  endtask

  task automatic reenable();
    en = 0; cyc(2);
    exp_cnt = 0; exp_err = 0;
    en = 1; cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    int first, second, k;
    logic [15:0] held;
    seed = $urandom(32'h5eed_1234);

    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count reset", count, 0);
    chk("R1 err reset", err, 0);
    chk("R1 snapshot reset", snap, 0);
    chk("R1 irq reset", irq, 0);

    // disabled: edges ignored
    move(1, 0); exp_cnt = 0;
    chk("R1 disabled count", count, 0);
    move(0, 0); exp_cnt = 0;

    en = 1; cyc(1);
    // latency: change lands by third edge
    a = 1; exp_cnt = 1;
    cyc(2);
    @(negedge clk);
    chk("R2 latency 3 edges", count, 1);
    cyc(2);
    fwd(); chk("R2 forward", count, exp_cnt);
    fwd(); chk("R2 forward", count, exp_cnt);
    rev(); chk("R2 reverse", count, exp_cnt);
    chk("R8 status A", status[0], a);
    chk("R8 status B", status[1], b);

    // wrap
    for (int i = 0; i < 12; i++) fwd();
    chk("R4 wrap up", count, exp_cnt);
    while (exp_cnt != 0) rev();
    rev(); chk("R4 wrap down", count, 10);

    // illegal double toggle
    held = count;
    move(~a, ~b);
    chk("R3 count held", count, held);
    chk("R3 err set", err, 1);
    fwd(); chk("R3 err sticky", err, 1);
    reenable();
    chk("R1 err cleared by disable", err, 0);

    // random walk
    for (int i = 0; i < 300; i++) begin
      k = $urandom_range(0, 99);
      if (k < 45) fwd();
      else if (k < 88) rev();
      else move(~a, ~b);
      chk("R2 R3 R4 random walk count", count, exp_cnt);
      chk("R3 random walk err", err, exp_err);
    end
    reenable();

    // markers, continuous
    z = 1; cyc(4);
    chk("R8 status marker", status[2], 1);
    z = 0; cyc(4);
    zen = 1;
    fwd(); fwd(); fwd();
    pulse_z(); exp_cnt = 0;
    chk("R5 marker clears", count, 0);
    fwd(); fwd();
    pulse_z(); exp_cnt = 0;
    chk("R5 second marker clears", count, 0);

    // single marker
    single = 1;
    reenable();
    fwd(); fwd(); fwd();
    pulse_z(); exp_cnt = 0;
    chk("R6 first marker clears", count, 0);
    fwd(); fwd();
    pulse_z();
    chk("R6 later marker ignored", count, exp_cnt);
    reenable();
    fwd();
    pulse_z(); exp_cnt = 0;
    chk("R6 re-armed by enable", count, 0);

    // marker disabled
    single = 0; zen = 0;
    fwd(); fwd();
    pulse_z();
    chk("R7 marker ignored", count, exp_cnt);

    // loop timer, linked
    held = count;
    period = 16'd7; link = 1; len = 1;
    first = -1; second = -1;
    for (int i = 0; i < 60 && second < 0; i++) begin
      @(negedge clk);
      if (irq) begin
        if (first < 0) first = i; else second = i;
        if (i > 0) begin
          @(negedge clk); i++;
          chk("R9 one-cycle pulse", irq, 0);
        end
      end
    end
    chk("R9 irq spacing", second - first, 8);
    chk("R10 snapshot linked", snap, held);

    // unlinked
    link = 0;
    cyc(2);
    fwd(); fwd();
    first = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) first++;
    end
    chk("R11 irq still pulses", first > 0, 1);
    chk("R11 snapshot held", snap, held);
    chk("R11 count moved", count, exp_cnt);

    finish_run();
  end
endmodule